// File: doc/BRIEF.md
# Guest Fault Address Refetch Tracker

An address-translation cache that keeps no guest physical address still has to report one when a lookup hits an entry marked with a guest page fault. This block sits beside such a cache. On the first non-prefetch lookup that hits a guest-faulting entry, it arms a single-entry wait slot. The slot holds the virtual page number and the reorder-buffer position of that request. The block then sends one table-walk request tagged "address only". The lookup itself is forced to report a miss. When the matching walk answer comes back, the block keeps the guest page number, the first-stage level and the leaf and fake-entry flags. When the same page is retried, the block lets the lookup complete: the miss is removed and the guest physical address is supplied.

While the slot waits, the block stops the cache from being refilled. The stop also covers the cycle in which the slot arms, and any address-only walk answer. The slot is discarded by a pipeline flush. It is also discarded by a redirect whose reorder position is not younger than the recorded one. The guest address offset comes from whichever of the two lookup addresses lies on the faulting page. The choice is made by comparing address bit 12.

Top module: `gpa_refetch_tracker`

## Requirements
- R1: A lookup with `lk_valid`, `lk_hit` and `lk_gpf` high and `lk_prefetch` low, seen while idle and not being served from the slot, asserts `req_valid` and `req_addr_only` in that same cycle with `req_vpn` equal to `lk_vpn`, and asserts `miss_force`.
- R2: A walk answer (`wk_valid`) is accepted only while waiting and only when `wk_vpn` equals the recorded page number. Acceptance ends the wait: from the next cycle `refill_block` falls unless something else holds it.
- R3: When an accepted answer has `wk_s2only` high, the guest page number is `wk_s2_tag`. Otherwise it is `wk_s1_ppn` with its low 9×`wk_level` bits replaced by the recorded page number (level 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB). `wk_level`, `wk_leaf` and `wk_fake` are returned on `gf_level`, `gf_leaf` and `gf_fake`.
- R4: After acceptance, a guest-faulting lookup of the recorded page gives `gpa_valid` high and `miss_force` low.
- R5: `refill_block` is high while waiting, in the cycle the slot arms, and in any cycle with `wk_valid` and `wk_addr_only` high.
- R6: A bypass answer (`bp_valid` with a matching `wk_vpn`) supplies the data at once. The wait ends one cycle later, so `refill_block` stays high for one more cycle.
- R7: A redirect whose (`redir_flag`, `redir_idx`) is older than or equal to the recorded position clears the slot. With equal flags, older means a smaller or equal index. With differing flags, older means a larger index. A younger redirect has no effect.
- R8: `flush` clears the slot unconditionally.
- R9: When bit 12 of `lk_fullva` differs from bit 12 of `lk_vaddr`, the address used is `lk_vaddr`; otherwise it is `lk_fullva`. With `lk_s2only` high, `gpa` is that address. Otherwise `gpa` is the guest page number followed by the address bits [11:0].
- R10: A prefetch lookup that hits a guest fault never arms, never requests a walk and never asserts `miss_force`.
- R11: While waiting, another guest-faulting lookup gets `miss_force` high, causes no request, and leaves the recorded page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present |
| lk_hit | input | 1 | Lookup hit a cached entry |
| lk_gpf | input | 1 | Hit entry carries a guest page fault |
| lk_prefetch | input | 1 | Lookup comes from a prefetcher |
| lk_s2only | input | 1 | Lookup runs in second-stage-only mode |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_vaddr | input | VADDR_W | Lookup address as presented to the cache |
| lk_fullva | input | FULLVA_W | Full original address of the request |
| lk_rob_flag | input | 1 | Reorder position wrap flag |
| lk_rob_idx | input | ROB_W | Reorder position index |
| wk_valid | input | 1 | Walk answer present |
| bp_valid | input | 1 | Bypass answer present on the walk path |
| wk_addr_only | input | 1 | Walk answer belongs to an address-only request |
| wk_vpn | input | VPN_W | Walk answer page number |
| wk_s2only | input | 1 | Walk answer is second-stage only |
| wk_s2_tag | input | GPN_W | Second-stage tag of the answer |
| wk_s1_ppn | input | GPN_W | First-stage page number of the answer |
| wk_level | input | 2 | First-stage level |
| wk_leaf | input | 1 | First-stage leaf flag |
| wk_fake | input | 1 | Fake-entry flag |
| redir_valid | input | 1 | Redirect present |
| redir_flag | input | 1 | Redirect wrap flag |
| redir_idx | input | ROB_W | Redirect index |
| flush | input | 1 | Pipeline flush |
| req_valid | output | 1 | Walk request |
| req_addr_only | output | 1 | Request is address only |
| req_vpn | output | VPN_W | Requested page number |
| miss_force | output | 1 | Override: report the lookup as a miss |
| refill_block | output | 1 | Refills of the cache are forbidden |
| gpa_valid | output | 1 | Fault completes with a guest address |
| gpa | output | GPN_W+12 | Guest physical address |
| gf_level | output | 2 | Stored first-stage level |
| gf_leaf | output | 1 | Stored leaf flag |
| gf_fake | output | 1 | Stored fake-entry flag |

## Verification
The bench uses the default widths: 27-bit page numbers, 38-bit guest page numbers, 50-bit lookup addresses, 64-bit full addresses and a 6-bit reorder index. With these widths, first-stage levels 0, 1 and 2 all fit inside the recorded page number. Each level replacement can therefore be checked against a hand-computed guest page number. The 6-bit index makes the wrap case reachable: an index of 60 with a clear flag, compared against 2 with a set flag, must count as older. Page-crossing pairs such as a full address ending in 0x5FFB against a lookup address ending in 0x6000 check the offset selection in both directions.

// File: rtl/gft_pkg.sv
package gft_pkg;
  localparam int GFT_OFF_W   = 12;
  localparam int GFT_LVL_BITS = 9;

  typedef enum logic [1:0] {
    GFT_LVL_4K = 2'd0,
    GFT_LVL_2M = 2'd1,
    GFT_LVL_1G = 2'd2
  } gft_level_e;
endpackage

// File: rtl/gft_age_cmp.sv
// True when position A is older than or equal to position B in a circular order
module gft_age_cmp #(
  parameter int IDX_W = 6
) (
  input  logic             a_flag,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_flag,
  input  logic [IDX_W-1:0] b_idx,
  output logic             a_not_younger
);
  always_comb begin
    if (a_flag == b_flag) a_not_younger = (a_idx <= b_idx);
    else                  a_not_younger = (a_idx > b_idx);
  end
endmodule

// File: rtl/gft_gpn_build.sv
// Guest page number from a walk answer
module gft_gpn_build
  import gft_pkg::*;
#(
  parameter int VPN_W = 27,
  parameter int GPN_W = 38
) (
  input  logic             s2only,
  input  logic [GPN_W-1:0] s2_tag,
  input  logic [GPN_W-1:0] s1_ppn,
  input  logic [1:0]       level,
  input  logic [VPN_W-1:0] vpn,
  output logic [GPN_W-1:0] gpn
);
  localparam int KEEP_MAX = 2 * GFT_LVL_BITS;

  logic [GPN_W-1:0] merged;
  int unsigned      keep;

  always_comb begin
    keep = 0;
    case (level)
      GFT_LVL_2M: keep = GFT_LVL_BITS;
      GFT_LVL_1G: keep = KEEP_MAX;
      default:    keep = 0;
    endcase
    for (int i = 0; i < GPN_W; i++) begin
      if (i < VPN_W && i < int'(keep)) merged[i] = vpn[i];
      else                             merged[i] = s1_ppn[i];
    end
    gpn = s2only ? s2_tag : merged;
  end
endmodule

// File: rtl/gft_gpa_form.sv
// Page-crossing offset choice and guest address assembly
module gft_gpa_form
  import gft_pkg::*;
#(
  parameter int FULLVA_W = 64,
  parameter int VADDR_W  = 50,
  parameter int GPN_W    = 38,
  localparam int GPA_W   = GPN_W + GFT_OFF_W
) (
  input  logic [FULLVA_W-1:0] fullva,
  input  logic [VADDR_W-1:0]  vaddr,
  input  logic                s2only,
  input  logic [GPN_W-1:0]    gpn,
  output logic [GPA_W-1:0]    gpa
);
  logic [VADDR_W-1:0] chosen;
  logic [GPA_W-1:0]   direct;

  assign chosen = (fullva[GFT_OFF_W] != vaddr[GFT_OFF_W]) ? vaddr : fullva[VADDR_W-1:0];

  generate
    if (GPA_W <= VADDR_W) begin : g_trunc
      assign direct = chosen[GPA_W-1:0];
    end else begin : g_ext
      assign direct = {{(GPA_W-VADDR_W){1'b0}}, chosen};
    end
  endgenerate

  assign gpa = s2only ? direct : {gpn, chosen[GFT_OFF_W-1:0]};
endmodule

// File: rtl/gpa_refetch_tracker.sv
module gpa_refetch_tracker
  import gft_pkg::*;
#(
  parameter int VPN_W    = 27,
  parameter int GPN_W    = 38,
  parameter int VADDR_W  = 50,
  parameter int FULLVA_W = 64,
  parameter int ROB_W    = 6,
  localparam int GPA_W   = GPN_W + GFT_OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic                lk_hit,
  input  logic                lk_gpf,
  input  logic                lk_prefetch,
  input  logic                lk_s2only,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [VADDR_W-1:0]  lk_vaddr,
  input  logic [FULLVA_W-1:0] lk_fullva,
  input  logic                lk_rob_flag,
  input  logic [ROB_W-1:0]    lk_rob_idx,
  input  logic                wk_valid,
  input  logic                bp_valid,
  input  logic                wk_addr_only,
  input  logic [VPN_W-1:0]    wk_vpn,
  input  logic                wk_s2only,
  input  logic [GPN_W-1:0]    wk_s2_tag,
  input  logic [GPN_W-1:0]    wk_s1_ppn,
  input  logic [1:0]          wk_level,
  input  logic                wk_leaf,
  input  logic                wk_fake,
  input  logic                redir_valid,
  input  logic                redir_flag,
  input  logic [ROB_W-1:0]    redir_idx,
  input  logic                flush,
  output logic                req_valid,
  output logic                req_addr_only,
  output logic [VPN_W-1:0]    req_vpn,
  output logic                miss_force,
  output logic                refill_block,
  output logic                gpa_valid,
  output logic [GPA_W-1:0]    gpa,
  output logic [1:0]          gf_level,
  output logic                gf_leaf,
  output logic                gf_fake
);
  // control state (reset)
  logic busy_q, busy_d;
  logic done_q, done_d;
  logic pend_q, pend_d;
  // recorded data (enable only)
  logic [VPN_W-1:0] rec_vpn_q;
  logic             rec_flag_q;
  logic [ROB_W-1:0] rec_idx_q;
  logic [GPN_W-1:0] gpn_q;
  logic [1:0]       lvl_q;
  logic             leaf_q, fake_q;

  logic             gf_lookup, served, arm, wk_take, bp_take, take, kill;
  logic             redir_old, ld_rec, ld_data;
  logic [GPN_W-1:0] gpn_new;

  gft_age_cmp #(.IDX_W(ROB_W)) u_age (
    .a_flag        (redir_flag),
    .a_idx         (redir_idx),
    .b_flag        (rec_flag_q),
    .b_idx         (rec_idx_q),
    .a_not_younger (redir_old)
  );

  gft_gpn_build #(.VPN_W(VPN_W), .GPN_W(GPN_W)) u_gpn (
    .s2only (wk_s2only),
    .s2_tag (wk_s2_tag),
    .s1_ppn (wk_s1_ppn),
    .level  (wk_level),
    .vpn    (rec_vpn_q),
    .gpn    (gpn_new)
  );

  gft_gpa_form #(.FULLVA_W(FULLVA_W), .VADDR_W(VADDR_W), .GPN_W(GPN_W)) u_gpa (
    .fullva (lk_fullva),
    .vaddr  (lk_vaddr),
    .s2only (lk_s2only),
    .gpn    (gpn_q),
    .gpa    (gpa)
  );

  always_comb begin
    gf_lookup = lk_valid & lk_hit & lk_gpf & ~lk_prefetch;
    served    = gf_lookup & done_q & (lk_vpn == rec_vpn_q);
    arm       = gf_lookup & ~busy_q & ~served & ~flush;
    wk_take   = wk_valid & busy_q & ~pend_q & (wk_vpn == rec_vpn_q);
    bp_take   = bp_valid & busy_q & ~pend_q & (wk_vpn == rec_vpn_q);
    take      = wk_take | bp_take;
    kill      = flush | (redir_valid & (busy_q | done_q) & redir_old);
    ld_rec    = arm & ~kill;
    ld_data   = take & ~kill;
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    pend_d = pend_q;
    if (kill) begin
      busy_d = 1'b0;
      done_d = 1'b0;
      pend_d = 1'b0;
    end else if (arm) begin
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (take) begin
      done_d = 1'b1;
      if (wk_take) busy_d = 1'b0;
      else         pend_d = 1'b1;
    end else if (pend_q) begin
      busy_d = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_rec) begin
      rec_vpn_q  <= lk_vpn;
      rec_flag_q <= lk_rob_flag;
      rec_idx_q  <= lk_rob_idx;
    end
    if (ld_data) begin
      gpn_q  <= gpn_new;
      lvl_q  <= wk_level;
      leaf_q <= wk_leaf;
      fake_q <= wk_fake;
    end
  end

  assign req_valid     = arm;
  assign req_addr_only = arm;
  assign req_vpn       = lk_vpn;
  assign miss_force    = gf_lookup & ~served;
  assign gpa_valid     = served;
  assign refill_block  = busy_q | arm | (wk_valid & wk_addr_only);
  assign gf_level      = lvl_q;
  assign gf_leaf       = leaf_q;
  assign gf_fake       = fake_q;
endmodule

// File: rtl/gft_tracker_chk.sv
module gft_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_prefetch,
  input logic flush,
  input logic redir_valid,
  input logic req_valid,
  input logic req_addr_only,
  input logic miss_force,
  input logic refill_block,
  input logic gpa_valid
);
  // R1: every walk request is flagged address only and overrides the miss
  a_r1_req_flags: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr_only && miss_force));

  // R5: refills are stopped in the cycle the slot arms
  a_r5_block_on_arm: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> refill_block);

  // R5: the cycle after arming, refills are still stopped
  a_r5_block_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flush && !redir_valid) |=> refill_block);

  // R11: no second request while waiting
  a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flush && !redir_valid) |=> !req_valid);

  // R4: a served lookup never reports a miss
  a_r4_served_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
    gpa_valid |-> !miss_force);

  // R8: nothing is served right after a flush
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !gpa_valid);

  // R10: prefetch lookups never arm the slot
  a_r10_prefetch_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_prefetch) |-> !req_valid);
endmodule

bind gpa_refetch_tracker gft_tracker_chk u_chk (.*);

// File: tb/gpa_refetch_tracker_test.sv
`timescale 1ns/1ps
module gpa_refetch_tracker_test;
  localparam int VPN_W = 27, GPN_W = 38, VADDR_W = 50, FULLVA_W = 64, ROB_W = 6;
  localparam int GPA_W = GPN_W + 12;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid, lk_hit, lk_gpf, lk_prefetch, lk_s2only, lk_rob_flag;
  logic [VPN_W-1:0] lk_vpn, wk_vpn;
  logic [VADDR_W-1:0] lk_vaddr;
  logic [FULLVA_W-1:0] lk_fullva;
  logic [ROB_W-1:0] lk_rob_idx, redir_idx;
  logic wk_valid, bp_valid, wk_addr_only, wk_s2only, wk_leaf, wk_fake;
  logic [GPN_W-1:0] wk_s2_tag, wk_s1_ppn;
  logic [1:0] wk_level;
  logic redir_valid, redir_flag, flush;
  logic req_valid, req_addr_only, miss_force, refill_block, gpa_valid;
  logic [VPN_W-1:0] req_vpn;
  logic [GPA_W-1:0] gpa;
  logic [1:0] gf_level;
  logic gf_leaf, gf_fake;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  gpa_refetch_tracker uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_hit = 0; lk_gpf = 0; lk_prefetch = 0; lk_s2only = 0;
    lk_vpn = '0; lk_vaddr = '0; lk_fullva = '0; lk_rob_flag = 0; lk_rob_idx = '0;
    wk_valid = 0; bp_valid = 0; wk_addr_only = 0; wk_vpn = '0; wk_s2only = 0;
    wk_s2_tag = '0; wk_s1_ppn = '0; wk_level = '0; wk_leaf = 0; wk_fake = 0;
    redir_valid = 0; redir_flag = 0; redir_idx = '0; flush = 0;
  endtask

  // drive at negedge, let combinational outputs settle
  task automatic step_idle();
    @(negedge clk); idle(); #5;
  endtask

  task automatic drive_gf(input logic [VPN_W-1:0] v, input logic f, input logic [ROB_W-1:0] i);
    @(negedge clk); idle();
    lk_valid = 1; lk_hit = 1; lk_gpf = 1; lk_vpn = v; lk_rob_flag = f; lk_rob_idx = i;
    lk_vaddr = {v, 12'h123}; lk_fullva = {{(FULLVA_W-VADDR_W){1'b0}}, v, 12'h123};
    #5;
  endtask

  task automatic arm(input logic [VPN_W-1:0] v, input logic f, input logic [ROB_W-1:0] i);
    drive_gf(v, f, i);
    chk("R1 req_valid", req_valid, 1);
    chk("R1 req_vpn", req_vpn, v);
    chk("R1 miss_force", miss_force, 1);
  endtask

  task automatic walk(input logic bypass, input logic [VPN_W-1:0] v, input logic s2,
                      input logic [GPN_W-1:0] tag, input logic [GPN_W-1:0] ppn,
                      input logic [1:0] lvl);
    @(negedge clk); idle();
    wk_valid = ~bypass; bp_valid = bypass; wk_addr_only = 1; wk_vpn = v; wk_s2only = s2;
    wk_s2_tag = tag; wk_s1_ppn = ppn; wk_level = lvl; wk_leaf = 1; wk_fake = 0;
    #5;
  endtask

  task automatic t_reset();
    step_idle();
    chk("reset req_valid", req_valid, 0);
    chk("reset refill_block", refill_block, 0);
    chk("reset gpa_valid", gpa_valid, 0);
    chk("reset miss_force", miss_force, 0);
  endtask

  task automatic t_level1_same_page();
    logic [VPN_W-1:0] a = 27'h1234567;
    logic [GPN_W-1:0] p = 38'h2A_BCDE_F012;
    logic [GPN_W-1:0] g;
    logic [63:0] fv;
    arm(a, 0, 6'd5);
    chk("R5 block on arm", refill_block, 1);
    // R11: another faulting page while waiting
    drive_gf(27'h0000ABC, 0, 6'd7);
    chk("R11 other miss", miss_force, 1);
    chk("R11 no req", req_valid, 0);
    walk(0, 27'h0000ABC, 0, '0, p, 2'd1);
    chk("R2 wrong vpn ignored (block)", refill_block, 1);
    step_idle();
    chk("R2 still waiting", refill_block, 1);
    walk(0, a, 0, '0, p, 2'd1);
    chk("R5 addr-only answer blocks", refill_block, 1);
    step_idle();
    chk("R2 wait over", refill_block, 0);
    g = (p & ~38'h1FF) | GPN_W'(a & 27'h1FF);
    fv = {{(FULLVA_W-VADDR_W){1'b0}}, a, 12'hABC};
    @(negedge clk); idle();
    lk_valid = 1; lk_hit = 1; lk_gpf = 1; lk_vpn = a; lk_fullva = fv; lk_vaddr = fv[VADDR_W-1:0];
    #5;
    chk("R4 gpa_valid", gpa_valid, 1);
    chk("R4 no miss", miss_force, 0);
    chk("R3/R9 gpa level1", gpa, {g, 12'hABC});
    chk("R3 level out", gf_level, 1);
    chk("R3 leaf out", gf_leaf, 1);
    // R9: page crossing, offset from lookup address
    lk_fullva = {{(FULLVA_W-VADDR_W){1'b0}}, a, 12'hFFB};
    lk_vaddr = {a + 27'd1, 12'h000};
    #1;
    chk("R9 cross offset", gpa, {g, 12'h000});
  endtask

  task automatic t_s2only_and_level2();
    logic [VPN_W-1:0] c = 27'h5A5A5A5;
    logic [GPN_W-1:0] t = 38'h15_5555_5555;
    logic [GPN_W-1:0] p = 38'h3F_0000_0000;
    logic [63:0] fv;
    arm(c, 0, 6'd9);
    walk(0, c, 1, t, p, 2'd2);
    @(negedge clk); idle();
    fv = 64'h0000_1234_5678_9ABC;
    lk_valid = 1; lk_hit = 1; lk_gpf = 1; lk_vpn = c; lk_fullva = fv; lk_vaddr = fv[VADDR_W-1:0];
    #5;
    chk("R3 s2only tag", gpa, {t, 12'hABC});
    lk_s2only = 1;
    #1;
    chk("R9 s2only direct", gpa, fv[GPA_W-1:0]);
    lk_vaddr = fv[VADDR_W-1:0] ^ 50'h1000;
    #1;
    chk("R9 s2only crossing", gpa, lk_vaddr);
    // level 2, non-s2only
    arm(27'h0012345, 0, 6'd11);
    walk(0, 27'h0012345, 0, '0, p, 2'd2);
    @(negedge clk); idle();
    lk_valid = 1; lk_hit = 1; lk_gpf = 1; lk_vpn = 27'h0012345;
    lk_fullva = 64'h0; lk_vaddr = '0;
    #5;
    chk("R3 level2 gpn", gpa, {(p & ~38'h3FFFF) | 38'h12345, 12'h000});
  endtask

  task automatic t_redirect();
    arm(27'h0000111, 0, 6'd10);
    @(negedge clk); idle(); redir_valid = 1; redir_flag = 0; redir_idx = 6'd12; #5;
    step_idle();
    chk("R7 younger redirect kept", refill_block, 1);
    @(negedge clk); idle(); redir_valid = 1; redir_flag = 0; redir_idx = 6'd10; #5;
    step_idle();
    chk("R7 equal redirect clears", refill_block, 0);
    arm(27'h0000222, 1, 6'd2);
    @(negedge clk); idle(); redir_valid = 1; redir_flag = 0; redir_idx = 6'd60; #5;
    step_idle();
    chk("R7 wrap older clears", refill_block, 0);
  endtask

  task automatic t_flush();
    arm(27'h0000333, 0, 6'd1);
    walk(0, 27'h0000333, 0, '0, 38'h1, 2'd0);
    @(negedge clk); idle(); flush = 1; #5;
    drive_gf(27'h0000333, 0, 6'd1);
    chk("R8 flushed not served", gpa_valid, 0);
    chk("R8 flushed rearms", req_valid, 1);
    @(negedge clk); idle(); flush = 1; #5;
    step_idle();
    chk("R8 flush ends wait", refill_block, 0);
  endtask

  task automatic t_prefetch();
    @(negedge clk); idle();
    lk_valid = 1; lk_hit = 1; lk_gpf = 1; lk_prefetch = 1; lk_vpn = 27'h444;
    #5;
    chk("R10 no req", req_valid, 0);
    chk("R10 no miss", miss_force, 0);
    step_idle();
    chk("R10 not armed", refill_block, 0);
  endtask

  task automatic t_bypass();
    logic [VPN_W-1:0] e = 27'h0000555;
    arm(e, 0, 6'd3);
    walk(1, e, 0, '0, 38'h0A_0000_0000, 2'd0);
    @(negedge clk); idle();
    lk_valid = 1; lk_hit = 1; lk_gpf = 1; lk_vpn = e; lk_fullva = 64'h0; lk_vaddr = '0;
    #5;
    chk("R6 block one more cycle", refill_block, 1);
    chk("R6 data usable", gpa_valid, 1);
    chk("R6 gpa", gpa, {38'h0A_0000_0000, 12'h000});
    step_idle();
    chk("R6 wait ends", refill_block, 0);
  endtask

  task automatic t_addr_only_idle();
    @(negedge clk); idle(); wk_valid = 1; wk_addr_only = 1; wk_vpn = 27'h9; #5;
    chk("R5 addr-only idle blocks", refill_block, 1);
    wk_addr_only = 0; #1;
    chk("R5 normal answer idle", refill_block, 0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_level1_same_page();
    t_s2only_and_level2();
    t_redirect();
    t_flush();
    t_prefetch();
    t_bypass();
    t_addr_only_idle();
    step_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule